// File: doc/BRIEF.md
# Deferred Frame CRC Checker

This block checks a serial framed bit stream against a CRC that arrives one frame late. Each frame's protected bits run through a CRC-6 engine. At the frame boundary the result is kept in a holding register. The next frame carries the CRC field for the frame before it. That field is collected as it streams past and compared with the held value when that next frame ends.

A mismatch raises a per-frame error flag and adds one to a saturating error counter, which a processor can read and clear. The frame position comes in on three side inputs from an external framer, which are sampled only with valid bits:
- a coverage mark,
- a CRC-field mark,
- an end-of-frame strobe.

A loss-of-alignment input discards the held CRC, so the next frame produces no verdict. Frame alignment and descrambling happen upstream.

Top module: `crc_lag_checker`

## Requirements
- R1: The frame CRC is CRC-6 with polynomial x^6+x+1, fed MSB-first. It starts from zero for each frame and advances only on cycles where `bit_vld_i` and `cov_i` are both 1.
- R2: Bits with `bit_vld_i`=1 and `fld_i`=1 are collected as the received CRC field. The first such bit in a frame becomes bit 5 (MSB) and the last becomes bit 0.
- R3: On `frame_end_i`, the field collected in the ending frame is compared with the CRC held from the previous frame. In the next cycle `err_flag_o` is 1 on a mismatch and 0 on a match.
- R4: `err_flag_o` keeps its value until the next compare or an `err_clr_i` pulse. If a clear and a mismatching compare fall in the same cycle, the flag ends at 1.
- R5: No compare is made, and the flag and counter are left alone, at the end of the first frame after reset or after a `sync_lost_i` pulse. If `sync_lost_i` and `frame_end_i` coincide, `sync_lost_i` wins.
- R6: Each mismatch increments the 8-bit `err_cnt_o`, which saturates at 255.
- R7: `err_clr_i` sets `err_cnt_o` to 0. If a mismatch happens in the same cycle, the count becomes 1.
- R8: A bit with `bit_vld_i`=0, or with both `cov_i`=0 and `fld_i`=0, changes neither the CRC nor the collected field.
- R9: After reset, `err_flag_o` is 0 and `err_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | `bit_i` carries a stream bit this cycle |
| cov_i | input | 1 | Current bit is covered by the CRC |
| fld_i | input | 1 | Current bit belongs to the CRC field |
| frame_end_i | input | 1 | Frame boundary strobe; a bit in the same cycle belongs to the ending frame |
| sync_lost_i | input | 1 | Alignment lost: drop the held CRC and restart |
| err_clr_i | input | 1 | Clear the error flag and the counter |
| err_flag_o | output | 1 | Mismatch at the last compare |
| err_cnt_o | output | 8 | Saturating error count |

## Verification
The embedded properties check these rules on every cycle:
- the flag and the counter move only at a frame boundary or on a clear;
- a boundary with no held CRC leaves both unchanged;
- the counter never steps by more than one, never wraps, and reads at most 1 after a clear.

Only the bench scenarios can show the values themselves. The bench computes CRCs independently over varied payloads and checks that a correct field passes and that inverted or bit-reversed fields fail. It also covers noise bits that must be ignored, restart after loss of alignment, a clear coinciding with an error, and saturation after more than 255 bad frames.

// File: rtl/crc_lag_pkg.sv
package crc_lag_pkg;
  localparam int unsigned CRC_W_DEF  = 6;
  localparam logic [5:0]  CRC_POLY_DEF = 6'h03;  // x^6 + x + 1, x^6 implied
  localparam int unsigned CNT_W_DEF  = 8;
endpackage

// File: rtl/crc_lag_accum.sv
module crc_lag_accum #(
  parameter int unsigned W    = 6,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_nxt_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  always_comb begin
    fb        = crc_q[W-1] ^ bit_i;
    crc_nxt_o = crc_q;
    if (shift_i) crc_nxt_o = {crc_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        crc_q <= '0;
    else if (restart_i) crc_q <= '0;
    else                crc_q <= crc_nxt_o;
  end

  // R8: without a shift the register holds
  assert_hold_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i && !restart_i |=> $stable(crc_q));
endmodule

// File: rtl/crc_lag_field.sv
module crc_lag_field #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] fld_nxt_o
);
  logic [W-1:0] fld_q;

  assign fld_nxt_o = shift_i ? {fld_q[W-2:0], bit_i} : fld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fld_q <= '0;
    else if (restart_i) fld_q <= '0;
    else                fld_q <= fld_nxt_o;
  end

  assert_field_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !restart_i |=> fld_q[0] == $past(bit_i));
endmodule

// File: rtl/crc_lag_errcnt.sv
module crc_lag_errcnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= inc_i ? CNT_W'(1) : '0;
    else if (inc_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CNT_MAX && !clr_i |=> cnt_q == CNT_MAX);
  assert_step_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1);
  assert_clear_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q <= CNT_W'(1));
endmodule

// File: rtl/crc_lag_checker.sv
module crc_lag_checker
  import crc_lag_pkg::*;
#(
  parameter int unsigned          CRC_W    = CRC_W_DEF,
  parameter logic [CRC_W-1:0]     CRC_POLY = CRC_POLY_DEF,
  parameter int unsigned          CNT_W    = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  input  logic             cov_i,
  input  logic             fld_i,
  input  logic             frame_end_i,
  input  logic             sync_lost_i,
  input  logic             err_clr_i,
  output logic             err_flag_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  logic             restart;
  logic             cmp_en;
  logic             mismatch;
  logic [CRC_W-1:0] crc_nxt;
  logic [CRC_W-1:0] fld_nxt;
  logic [CRC_W-1:0] hold_q;
  logic             hold_vld_q;
  logic             flag_q;

  assign restart  = frame_end_i | sync_lost_i;
  assign cmp_en   = frame_end_i & hold_vld_q & ~sync_lost_i;
  assign mismatch = cmp_en & (fld_nxt != hold_q);

  crc_lag_accum #(.W(CRC_W), .POLY(CRC_POLY)) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .shift_i   (bit_vld_i & cov_i),
    .bit_i     (bit_i),
    .crc_nxt_o (crc_nxt)
  );

  crc_lag_field #(.W(CRC_W)) u_field (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .shift_i   (bit_vld_i & fld_i),
    .bit_i     (bit_i),
    .fld_nxt_o (fld_nxt)
  );

  // Frame N result carried across the boundary for the check in frame N+1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (sync_lost_i) begin
      hold_vld_q <= 1'b0;
    end else if (frame_end_i) begin
      hold_q     <= crc_nxt;
      hold_vld_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (mismatch)  flag_q <= 1'b1;
    else if (cmp_en)    flag_q <= 1'b0;
    else if (err_clr_i) flag_q <= 1'b0;
  end

  assign err_flag_o = flag_q;

  crc_lag_errcnt #(.CNT_W(CNT_W)) u_errcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (mismatch),
    .clr_i  (err_clr_i),
    .cnt_o  (err_cnt_o)
  );

  assert_flag_only_at_cmp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i && !err_clr_i |=> $stable(err_flag_o));
  assert_cnt_only_at_cmp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i && !err_clr_i |=> $stable(err_cnt_o));
  assert_first_frame_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i || sync_lost_i) && !hold_vld_q && !err_clr_i |=> $stable(err_flag_o));
  assert_first_frame_cnt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i && (!hold_vld_q || sync_lost_i) && !err_clr_i |=> $stable(err_cnt_o));
  assert_clr_wins_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !frame_end_i |=> !err_flag_o);
endmodule

// File: tb/sim_crc_lag_checker.sv
module sim_crc_lag_checker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0, bit_vld_i = 1'b0, cov_i = 1'b0, fld_i = 1'b0;
  logic       frame_end_i = 1'b0, sync_lost_i = 1'b0, err_clr_i = 1'b0;
  logic       err_flag_o;
  logic [7:0] err_cnt_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [5:0] m_prev = '0;
  bit         m_vld  = 0;
  logic       m_flag = 0;
  int         m_cnt  = 0;

  always #4 clk_i = ~clk_i;

  crc_lag_checker u0 (.*);

  function automatic logic [5:0] ref_crc(input logic [15:0] pay);
    logic [5:0] c = '0;
    for (int i = 15; i >= 0; i--) begin
      logic fb = c[5] ^ pay[i];
      c = {c[4:0], 1'b0};
      if (fb) c = c ^ 6'b000011;
    end
    return c;
  endfunction

  function automatic logic [5:0] rev6(input logic [5:0] v);
    return {v[0], v[1], v[2], v[3], v[4], v[5]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic b, input logic v, input logic c, input logic f);
    @(negedge clk_i);
    bit_i = b; bit_vld_i = v; cov_i = c; fld_i = f;
  endtask

  // mode: 0 correct field, 1 inverted, 2 bit-reversed
  task automatic do_frame(input logic [15:0] pay, input int mode, input bit clr,
                          input bit noise, input string tag);
    logic [5:0] fld;
    bit         mism;
    fld = (mode == 1) ? ~m_prev : (mode == 2) ? rev6(m_prev) : m_prev;
    if (!m_vld) fld = 6'h2A;
    for (int i = 15; i >= 0; i--) begin
      drive(pay[i], 1'b1, 1'b1, 1'b0);
      if (noise) begin
        drive(~pay[i], 1'b0, 1'b1, 1'b1);  // no valid: ignored (R8)
        drive(1'b1, 1'b1, 1'b0, 1'b0);     // uncovered: ignored (R8)
      end
    end
    for (int i = 5; i >= 0; i--) drive(fld[i], 1'b1, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    frame_end_i = 1'b1; err_clr_i = clr;
    @(negedge clk_i);
    frame_end_i = 1'b0; err_clr_i = 1'b0;
    mism = m_vld && (fld != m_prev);
    if (mism)       m_flag = 1;
    else if (m_vld) m_flag = 0;
    else if (clr)   m_flag = 0;
    if (clr)                        m_cnt = mism ? 1 : 0;
    else if (mism && m_cnt < 255)   m_cnt++;
    m_prev = ref_crc(pay); m_vld = 1;
    chk({tag, " flag"}, int'(err_flag_o), int'(m_flag));
    chk({tag, " cnt"},  int'(err_cnt_o),  m_cnt);
  endtask

  task automatic t_reset;
    chk("R9 reset flag", int'(err_flag_o), 0);
    chk("R9 reset cnt",  int'(err_cnt_o), 0);
  endtask

  task automatic t_first_frame;
    do_frame(16'hA5C3, 1, 0, 0, "R5 first frame after reset");
  endtask

  task automatic t_good_bad;
    do_frame(16'h1234, 0, 0, 0, "R1 R3 good");
    do_frame(16'hFFFF, 0, 0, 0, "R1 R3 good ones");
    do_frame(16'h0001, 1, 0, 0, "R3 R6 inverted");
    repeat (5) @(negedge clk_i);
    chk("R4 flag holds", int'(err_flag_o), 1);
    do_frame(16'h8000, 0, 0, 0, "R3 R4 match clears");
    do_frame(16'h3C5A, 2, 0, 0, "R2 reversed order");
  endtask

  task automatic t_noise;
    do_frame(16'hBEEF, 0, 0, 1, "R8 noise good");
    do_frame(16'h0F0F, 0, 0, 1, "R8 noise good 2");
  endtask

  task automatic t_sync_lost;
    @(negedge clk_i); sync_lost_i = 1'b1;
    @(negedge clk_i); sync_lost_i = 1'b0;
    m_vld = 0;
    do_frame(16'h7777, 1, 0, 0, "R5 after sync loss");
    do_frame(16'h4321, 0, 0, 0, "R5 compare resumes");
    // coincident sync loss and frame end: no verdict
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b1, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    frame_end_i = 1'b1; sync_lost_i = 1'b1;
    @(negedge clk_i);
    frame_end_i = 1'b0; sync_lost_i = 1'b0;
    m_vld = 0;
    chk("R5 coincident cnt", int'(err_cnt_o), m_cnt);
    do_frame(16'h5555, 1, 0, 0, "R5 first after coincident");
  endtask

  task automatic t_clear;
    do_frame(16'h2468, 1, 0, 0, "R6 err before clear");
    repeat (2) @(negedge clk_i);
    err_clr_i = 1'b1;
    @(negedge clk_i);
    err_clr_i = 1'b0;
    m_cnt = 0; m_flag = 0;
    chk("R7 clear cnt",  int'(err_cnt_o), 0);
    chk("R4 clear flag", int'(err_flag_o), 0);
    do_frame(16'h1357, 1, 1, 0, "R7 R4 clear with error");
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 260; k++) do_frame(16'(k * 97 + 11), 1, 0, 0, "R6 saturate");
    chk("R6 saturated at 255", int'(err_cnt_o), 255);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_first_frame();
    t_good_bad();
    t_noise();
    t_sync_lost();
    t_clear();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule